// File: doc/BRIEF.md
# Fine-Grain Barrel Thread Scheduler

This block decides, on every clock cycle, which hardware context of a fine-grain multithreaded core issues its next instruction. A context can be chosen only when the pipeline has it allocated, it has an instruction ready, and it is not stalled. Contexts that qualify are served in rotating order, and the choice may move to a different context on every cycle.

The block also enforces two limits for each context. The first is on memory operations in flight. The second comes from the lookahead count carried by each memory instruction, which caps how many further instructions the context may issue while it waits for that memory result. The pipeline tells the block, for each context, whether that context's next instruction is a memory operation. When a memory instruction issues, its lookahead value comes with it on the same cycle. The memory system reports each completion as a one-cycle pulse with a context ID.

The selection output is combinational from the registered state and the current inputs. The selected instruction is taken as issued at the next rising clock edge, and all state updates happen at that edge.

Top module: `barrel_sched`

## Requirements
- R1: While reset is held, and after reset with no context offered, `valid_o` is 0. Reset clears every context's lookahead credit, waiting state and outstanding count, and sets the rotation pointer to context 0.
- R2: A context can be granted only if its bits in `ctx_en_i` and `ctx_rdy_i` are 1 and its bit in `ctx_stall_i` is 0.
- R3: The grant goes to the first eligible context found by searching upward from the rotation pointer and wrapping from N_CTX-1 to 0. After each grant, the pointer moves to the context after the granted one.
- R4: In a cycle with no eligible context, `valid_o` is 0 and the pointer keeps its value.
- R5: When a context is granted with its `mem_op_i` bit set, its credit is loaded from `lookahead_i` and the context enters the waiting state. Each later non-memory grant to that context lowers the credit by one. A context that is waiting with zero credit cannot be granted.
- R6: A completion pulse (`cmpl_valid_i` with `cmpl_ctx_i`) lowers that context's outstanding count by one and ends its waiting state, taking effect at the next edge. A completion that arrives for a context with no outstanding operations is ignored.
- R7: A context with MAX_OUT memory operations outstanding cannot be granted while its `mem_op_i` bit is 1. With that bit at 0 the context remains eligible.
- R8: A memory grant and a completion for the same context in the same cycle are both applied: the outstanding count is left unchanged and the context stays waiting with its credit reloaded.
- R9: A memory grant with `lookahead_i` = 0 makes the context ineligible from the next cycle until a completion for it has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctx_en_i | input | N_CTX | Context allocated to a thread |
| ctx_rdy_i | input | N_CTX | Context has an instruction available |
| ctx_stall_i | input | N_CTX | Context blocked by the pipeline |
| mem_op_i | input | N_CTX | Next instruction of the context is a memory operation |
| lookahead_i | input | LA_W | Lookahead count of the instruction granted this cycle |
| cmpl_valid_i | input | 1 | Memory completion pulse |
| cmpl_ctx_i | input | IDW | Context ID of the completion |
| sel_o | output | IDW | Granted context ID |
| valid_o | output | 1 | A context is granted this cycle |

## Verification
On every cycle, the assertions check the following. A grant goes only to an offered context. No grant appears when nothing is offered. A zero-lookahead memory grant is never followed at once by another grant to the same context. The checker also counts memory operations per context, and no memory grant may exceed MAX_OUT. Only the bench scenarios can show the remaining behaviour: the exact rotation order and its wrap, a pointer that holds across idle cycles, the exact number of instructions a credit allows, release by a completion, and the combined effect of a completion and a memory grant in the same cycle, which shows up later as the point where the outstanding limit takes hold.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ctx_gate.sv
module ctx_gate #(
  parameter int unsigned LA_W    = 4,
  parameter int unsigned MAX_OUT = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic            mem_i,
  input  logic [LA_W-1:0] la_i,
  input  logic            cmpl_i,
  output logic            open_o,
  output logic            full_o
);
  localparam int unsigned OW = $clog2(MAX_OUT + 1);

  logic [LA_W-1:0] credit_q;
  logic            wait_q;
  logic [OW-1:0]   outst_q;
  logic            inc, dec;

  assign inc = issue_i && mem_i;
  assign dec = cmpl_i && (outst_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= '0;
      wait_q   <= 1'b0;
    end else if (inc) begin
      credit_q <= la_i;
      wait_q   <= 1'b1;
    end else begin
      if (issue_i && credit_q != '0) credit_q <= credit_q - 1'b1;
      if (cmpl_i) wait_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else if (inc && !dec) outst_q <= outst_q + 1'b1;
    else if (dec && !inc) outst_q <= outst_q - 1'b1;
  end

  assign open_o = !(wait_q && credit_q == '0);
  assign full_o = (outst_q == OW'(MAX_OUT));
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N   = 8,
  parameter int unsigned IDW = 3
) (
  input  logic [N-1:0]   req_i,
  input  logic [IDW-1:0] ptr_i,
  output logic           gnt_o,
  output logic [IDW-1:0] id_o
);
  always_comb begin
    gnt_o = 1'b0;
    id_o  = '0;
    for (int i = 0; i < int'(N); i++) begin
      int idx;
      idx = int'(ptr_i) + i;
      if (idx >= int'(N)) idx = idx - int'(N);
      if (!gnt_o && req_i[idx]) begin
        gnt_o = 1'b1;
        id_o  = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/barrel_sched.sv
module barrel_sched #(
  parameter int unsigned N_CTX   = 8,
  parameter int unsigned LA_W    = 4,
  parameter int unsigned MAX_OUT = 8,
  parameter int unsigned IDW     = barrel_pkg::id_width(N_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CTX-1:0] ctx_en_i,
  input  logic [N_CTX-1:0] ctx_rdy_i,
  input  logic [N_CTX-1:0] ctx_stall_i,
  input  logic [N_CTX-1:0] mem_op_i,
  input  logic [LA_W-1:0]  lookahead_i,
  input  logic             cmpl_valid_i,
  input  logic [IDW-1:0]   cmpl_ctx_i,
  output logic [IDW-1:0]   sel_o,
  output logic             valid_o
);
  logic [N_CTX-1:0] gate_open, out_full, elig;
  logic [IDW-1:0]   ptr_q;

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    logic issue, cmpl;
    assign issue = valid_o && (sel_o == IDW'(c));
    assign cmpl  = cmpl_valid_i && (cmpl_ctx_i == IDW'(c));

    ctx_gate #(.LA_W(LA_W), .MAX_OUT(MAX_OUT)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .issue_i(issue),
      .mem_i  (mem_op_i[c]),
      .la_i   (lookahead_i),
      .cmpl_i (cmpl),
      .open_o (gate_open[c]),
      .full_o (out_full[c])
    );

    assign elig[c] = ctx_en_i[c] && ctx_rdy_i[c] && !ctx_stall_i[c]
                     && gate_open[c] && !(mem_op_i[c] && out_full[c]);
  end

  rr_pick #(.N(N_CTX), .IDW(IDW)) u_pick (
    .req_i(elig),
    .ptr_i(ptr_q),
    .gnt_o(valid_o),
    .id_o (sel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (valid_o) ptr_q <= (sel_o == IDW'(N_CTX - 1)) ? '0 : sel_o + 1'b1;
  end
endmodule

// File: rtl/barrel_sched_chk.sv
module barrel_sched_chk #(
  parameter int unsigned N_CTX   = 8,
  parameter int unsigned LA_W    = 4,
  parameter int unsigned MAX_OUT = 8,
  parameter int unsigned IDW     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CTX-1:0] ctx_en_i,
  input logic [N_CTX-1:0] ctx_rdy_i,
  input logic [N_CTX-1:0] ctx_stall_i,
  input logic [N_CTX-1:0] mem_op_i,
  input logic [LA_W-1:0]  lookahead_i,
  input logic             cmpl_valid_i,
  input logic [IDW-1:0]   cmpl_ctx_i,
  input logic [IDW-1:0]   sel_o,
  input logic             valid_o
);
  localparam int unsigned OW = $clog2(MAX_OUT + 2);
  logic [OW-1:0] cnt_q [N_CTX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < int'(N_CTX); c++) cnt_q[c] <= '0;
    end else begin
      for (int c = 0; c < int'(N_CTX); c++) begin
        logic up, dn;
        up = valid_o && sel_o == IDW'(c) && mem_op_i[c];
        dn = cmpl_valid_i && cmpl_ctx_i == IDW'(c) && cnt_q[c] != '0;
        if (up && !dn) cnt_q[c] <= cnt_q[c] + 1'b1;
        else if (dn && !up) cnt_q[c] <= cnt_q[c] - 1'b1;
      end
    end
  end

  a_r2_offered_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ctx_en_i[sel_o] && ctx_rdy_i[sel_o] && !ctx_stall_i[sel_o]));

  a_r4_idle_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctx_en_i & ctx_rdy_i & ~ctx_stall_i) == '0) |-> !valid_o);

  a_r9_zero_lookahead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mem_op_i[sel_o] && lookahead_i == '0)
      |=> !(valid_o && sel_o == $past(sel_o)));

  a_r7_out_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mem_op_i[sel_o]) |-> (cnt_q[sel_o] < OW'(MAX_OUT)));
endmodule

bind barrel_sched barrel_sched_chk #(
  .N_CTX(N_CTX), .LA_W(LA_W), .MAX_OUT(MAX_OUT), .IDW(IDW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctx_en_i(ctx_en_i), .ctx_rdy_i(ctx_rdy_i),
  .ctx_stall_i(ctx_stall_i), .mem_op_i(mem_op_i), .lookahead_i(lookahead_i),
  .cmpl_valid_i(cmpl_valid_i), .cmpl_ctx_i(cmpl_ctx_i), .sel_o(sel_o),
  .valid_o(valid_o)
);

// File: tb/barrel_sched_tb.sv
module barrel_sched_tb;
  localparam int N = 8;
  localparam int LW = 4;
  localparam int IW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  ctx_en_i = '0, ctx_rdy_i = '0, ctx_stall_i = '0, mem_op_i = '0;
  logic [LW-1:0] lookahead_i = '0;
  logic          cmpl_valid_i = 1'b0;
  logic [IW-1:0] cmpl_ctx_i = '0;
  logic [IW-1:0] sel_o;
  logic          valid_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  barrel_sched u_dut (.*);

  task automatic expect_pick(input bit ev, input int eid, input string req);
    n_chk++;
    if (valid_o !== ev || (ev && sel_o !== IW'(eid))) begin
      n_bad++;
      $display("FAIL %s: valid=%0b sel=%0d expected valid=%0b sel=%0d",
               req, valid_o, sel_o, ev, eid);
    end
  endtask

  // drive after falling edge, sample half way to the next rising edge
  task automatic cyc_begin();
    @(negedge clk_i);
    cmpl_valid_i = 1'b0;
  endtask

  task automatic settle();
    #5;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #5;
    expect_pick(0, 0, "R1 during reset");
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    settle();
    expect_pick(0, 0, "R1 after reset, none offered");
  endtask

  task automatic t_rotate();
    for (int k = 0; k < 9; k++) begin
      cyc_begin();
      ctx_en_i = '1; ctx_rdy_i = '1; ctx_stall_i = '0; mem_op_i = '0;
      settle();
      expect_pick(1, k % N, "R3 rotation with wrap");
    end
  endtask

  task automatic t_skip();
    int exp_ids[4] = '{2, 5, 7, 2};
    for (int k = 0; k < 4; k++) begin
      cyc_begin();
      ctx_rdy_i = 8'hA4;
      settle();
      expect_pick(1, exp_ids[k], "R2 skip contexts without instruction");
    end
  endtask

  task automatic t_idle();
    for (int k = 0; k < 2; k++) begin
      cyc_begin();
      ctx_rdy_i = '0;
      settle();
      expect_pick(0, 0, "R4 nothing eligible");
    end
    cyc_begin();
    ctx_rdy_i = '1;
    settle();
    expect_pick(1, 3, "R4 pointer held over idle");
  endtask

  task automatic t_masks();
    cyc_begin();
    ctx_stall_i = ~(8'h40);
    settle();
    expect_pick(1, 6, "R2 stalled contexts skipped");
    cyc_begin();
    ctx_stall_i = '0; ctx_en_i = 8'h01;
    settle();
    expect_pick(1, 0, "R2 disabled contexts skipped");
    cyc_begin();
    ctx_en_i = 8'h03;
    settle();
    expect_pick(1, 1, "R3 next after granted");
  endtask

  task automatic t_lookahead();
    cyc_begin();
    ctx_en_i = '1; ctx_rdy_i = 8'h02; mem_op_i = 8'h02; lookahead_i = 4'd2;
    settle();
    expect_pick(1, 1, "R5 memory grant");
    for (int k = 0; k < 2; k++) begin
      cyc_begin();
      mem_op_i = '0; lookahead_i = '0;
      settle();
      expect_pick(1, 1, "R5 grant within credit");
    end
    cyc_begin();
    cmpl_valid_i = 1'b1; cmpl_ctx_i = 3'd1;
    settle();
    expect_pick(0, 0, "R5 credit exhausted");
    cyc_begin();
    settle();
    expect_pick(1, 1, "R6 completion releases context");
  endtask

  task automatic t_zero_la();
    cyc_begin();
    mem_op_i = 8'h02; lookahead_i = '0;
    settle();
    expect_pick(1, 1, "R9 memory grant with zero lookahead");
    cyc_begin();
    mem_op_i = '0;
    cmpl_valid_i = 1'b1; cmpl_ctx_i = 3'd1;
    settle();
    expect_pick(0, 0, "R9 blocked right after");
    cyc_begin();
    settle();
    expect_pick(1, 1, "R6 released by completion");
  endtask

  task automatic t_outstanding();
    for (int k = 0; k < 8; k++) begin
      cyc_begin();
      ctx_rdy_i = 8'h08; mem_op_i = 8'h08; lookahead_i = 4'd15;
      settle();
      expect_pick(1, 3, "R7 memory grant below limit");
    end
    cyc_begin();
    settle();
    expect_pick(0, 0, "R7 limit reached");
    cyc_begin();
    mem_op_i = '0;
    settle();
    expect_pick(1, 3, "R7 non-memory allowed at limit");
    cyc_begin();
    mem_op_i = 8'h08; cmpl_valid_i = 1'b1; cmpl_ctx_i = 3'd3;
    settle();
    expect_pick(0, 0, "R7 still full before completion applies");
    cyc_begin();
    cmpl_valid_i = 1'b1; cmpl_ctx_i = 3'd3;
    settle();
    expect_pick(1, 3, "R8 grant alongside completion");
    cyc_begin();
    settle();
    expect_pick(1, 3, "R8 one slot left after paired update");
    cyc_begin();
    settle();
    expect_pick(0, 0, "R8 limit reached again");
  endtask

  initial begin
    t_reset();
    t_rotate();
    t_skip();
    t_idle();
    t_masks();
    t_lookahead();
    t_zero_la();
    t_outstanding();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule